// File: doc/BRIEF.md
# Duplex-Aware Transmit Deferral Controller

This block decides when an Ethernet MAC may start a frame. It watches carrier sense, receive activity, collision and the MAC's own transmit activity. It counts the inter-packet gap in bit-time ticks and raises a transmit grant once a frame is pending, the gap has run out and nothing in the current duplex mode calls for deferral. It also passes the collision signal on to the MAC and reports loss of carrier during a transmission.

In half duplex, any activity on the medium defers transmission and restarts the gap. After each transmission, carrier sense is ignored for a short blinding window, during which the heartbeat test would take place. In full duplex only the device's own transmission defers and restarts the gap. Carrier sense and receive activity are ignored, there is no blinding window, the collision path is masked and loss-of-carrier reports are suppressed.

Top module: `txdefer_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `ipg_busy`, `lcar_err` and the blinding window are all inactive, so a pending frame is granted unless a deferral input is active.
- R2: `tx_grant` is high exactly when `tx_pending` is high, the gap counter is zero and the mode's deferral condition is absent. This is combinational in the current cycle.
- R3: In half duplex, the deferral condition is `tx_active`, `rx_active`, or `crs` outside the blinding window. Each such cycle reloads the gap counter to IPG_TICKS. `ipg_busy` falls in the cycle after the IPG_TICKS-th tick that arrives while no deferral condition is present.
- R4: In full duplex, only `tx_active` defers and reloads the gap counter. `crs` and `rx_active` have no effect on `tx_grant` or `ipg_busy`.
- R5: In half duplex, the cycle after `tx_active` falls opens a window of BLIND_TICKS ticks. During this window `crs` neither defers nor reloads the gap, and it cannot raise loss of carrier.
- R6: `col_out` equals `col_in` in half duplex and is held at 0 in full duplex.
- R7: In half duplex, `lcar_err` pulses for one cycle. The pulse comes in the cycle after the first cycle of a transmission in which `tx_active` is high, `crs` is low and the blinding window is closed. There is at most one pulse per transmission, that is, per run of `tx_active` high.
- R8: In full duplex, `lcar_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per bit time |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| crs | input | 1 | Carrier sense |
| rx_active | input | 1 | Receive in progress |
| col_in | input | 1 | Raw collision indication |
| tx_active | input | 1 | MAC is transmitting |
| tx_pending | input | 1 | MAC has a frame waiting |
| tx_grant | output | 1 | Permission to start transmitting |
| ipg_busy | output | 1 | Gap counter still running |
| col_out | output | 1 | Collision seen by the MAC |
| lcar_err | output | 1 | Loss-of-carrier strobe |

## Verification
The assertions assume the following about the inputs:
- `full_duplex` changes only while the link is idle.
- IPG_TICKS is nonzero.
- `tx_active` forms contiguous runs, so that one run means one frame.

The stimulus changes the mode only between scenarios, after every activity input has been low for several cycles. It drives `tx_active` as solid bursts, including the random bursts. `tick` is pulsed on alternate cycles in part of the run, so that the gap and blinding counts are measured in ticks and not in clock cycles.

// File: rtl/txdefer_ctrl.sv
module txdefer_ctrl #(
  parameter int IPG_TICKS   = 96,
  parameter int BLIND_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic full_duplex,
  input  logic crs,
  input  logic rx_active,
  input  logic col_in,
  input  logic tx_active,
  input  logic tx_pending,
  output logic tx_grant,
  output logic ipg_busy,
  output logic col_out,
  output logic lcar_err
);
  localparam int IPG_W   = $clog2(IPG_TICKS + 1);
  localparam int BLIND_W = $clog2(BLIND_TICKS + 1);

  logic [IPG_W-1:0]   ipg_cnt;
  logic [BLIND_W-1:0] blind_cnt;
  logic tx_d, lcar_seen;

  wire blinded  = (blind_cnt != '0) && !full_duplex;
  wire crs_seen = crs && !blinded;
  wire defer    = full_duplex ? tx_active : (tx_active || rx_active || crs_seen);
  wire tx_fall  = tx_d && !tx_active;
  wire lcar_hit = !full_duplex && tx_active && !crs && !blinded && !lcar_seen;

  assign ipg_busy = (ipg_cnt != '0);
  assign tx_grant = tx_pending && !ipg_busy && !defer;
  assign col_out  = col_in && !full_duplex;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipg_cnt <= '0;
    end else if (defer) begin
      ipg_cnt <= IPG_W'(IPG_TICKS);
    end else if (tick && ipg_busy) begin
      ipg_cnt <= ipg_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || full_duplex) begin
      blind_cnt <= '0;
    end else if (tx_fall) begin
      blind_cnt <= BLIND_W'(BLIND_TICKS);
    end else if (tick && blind_cnt != '0) begin
      blind_cnt <= blind_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_d      <= 1'b0;
      lcar_seen <= 1'b0;
      lcar_err  <= 1'b0;
    end else begin
      tx_d      <= tx_active;
      lcar_err  <= lcar_hit;
      lcar_seen <= tx_active && (lcar_seen || lcar_hit);
    end
  end

  AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    defer |=> ipg_busy); // R3
  AST_FD_NO_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |=> (blind_cnt == '0)); // R5
  AST_LCAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lcar_err |=> !lcar_err); // R7
  AST_FD_NO_LCAR: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && $past(full_duplex)) |-> !lcar_err); // R8
  AST_FD_RX_NO_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && !tx_active && !ipg_busy && tx_pending) |-> tx_grant); // R4
endmodule

// File: tb/txdefer_ctrl_tb.sv
module txdefer_ctrl_tb_top;
  localparam int IPG   = 96;
  localparam int BLIND = 40;

  logic clk = 1'b0;
  logic rst_n, tick, fd, crs, rx, col, tx, pend;
  logic grant, busy, colo, lcar;
  int checks = 0, errors = 0, cyc = 0;
  bit tick_slow = 0;

  int  m_ipg, m_blind;
  bit  m_txd, m_seen, m_lcar;

  always #10 clk = ~clk;

  txdefer_ctrl #(.IPG_TICKS(IPG), .BLIND_TICKS(BLIND)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .full_duplex(fd), .crs(crs),
    .rx_active(rx), .col_in(col), .tx_active(tx), .tx_pending(pend),
    .tx_grant(grant), .ipg_busy(busy), .col_out(colo), .lcar_err(lcar));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      bit blind_on, deferm, e_grant;
      tick = tick_slow ? (cyc % 2 == 0) : 1'b1;
      #8;
      blind_on = (m_blind > 0) && !fd;
      deferm   = fd ? tx : (tx || rx || (crs && !blind_on));
      e_grant  = pend && (m_ipg == 0) && !deferm;
      chk(fd ? "R2/R4 grant" : "R2/R3/R5 grant", grant, e_grant);
      chk(fd ? "R4 ipg_busy" : "R3/R5 ipg_busy", busy, m_ipg != 0);
      chk("R6 col_out", colo, col && !fd);
      chk(fd ? "R8 lcar_err" : "R7 lcar_err", lcar, m_lcar);
      @(posedge clk);
      if (!rst_n) begin
        m_ipg = 0; m_blind = 0; m_txd = 0; m_seen = 0; m_lcar = 0;
      end else begin
        bit hit;
        hit = !fd && tx && !crs && !blind_on && !m_seen;
        if (deferm) m_ipg = IPG;
        else if (tick && m_ipg > 0) m_ipg--;
        if (fd) m_blind = 0;
        else if (m_txd && !tx) m_blind = BLIND;
        else if (tick && m_blind > 0) m_blind--;
        m_lcar = hit;
        m_seen = tx && (m_seen || hit);
        m_txd  = tx;
      end
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic idle_all();
    crs = 0; rx = 0; col = 0; tx = 0;
  endtask

  task automatic frame(input int len, input bit carrier, input int echo);
    tx = 1; crs = carrier; step(len);
    tx = 0; step(echo > 0 ? echo : 0);
    crs = 0;
  endtask

  initial begin
    rst_n = 0; tick = 1; fd = 0; pend = 1; idle_all();
    m_ipg = 0; m_blind = 0; m_txd = 0; m_seen = 0; m_lcar = 0;
    @(negedge clk);
    step(3);
    rst_n = 1;
    // R1: first cycle after reset, pending frame granted, no gap
    #8; chk("R1 grant", grant, 1'b1); chk("R1 ipg_busy", busy, 1'b0); chk("R1 lcar", lcar, 1'b0);
    @(negedge clk);
    step(2);
    // R3/R5: half-duplex frame with carrier echo inside blinding window
    frame(30, 1, 10); step(120);
    // R3: receive activity defers and reloads the gap
    rx = 1; step(20); rx = 0; step(110);
    // R5: carrier after blinding window reloads gap
    frame(20, 1, 1); step(BLIND + 10); crs = 1; step(3); crs = 0; step(110);
    // R7: carrier drops mid-frame, single strobe
    tx = 1; crs = 1; step(10); crs = 0; step(5); crs = 1; step(3); crs = 0; step(4);
    tx = 0; step(110);
    // R6: collisions pass in half duplex
    tx = 1; crs = 1; col = 1; step(4); col = 0; step(4); tx = 0; crs = 0; step(100);
    // R3/R5 with slow ticks
    tick_slow = 1; frame(12, 1, 5); step(2 * IPG + 20); tick_slow = 0;
    // R4/R6/R8: full duplex
    idle_all(); step(5); fd = 1; step(2);
    rx = 1; crs = 1; step(15);
    col = 1; step(3); col = 0;
    tx = 1; crs = 0; step(20); tx = 0; step(10);
    rx = 0; step(100);
    tx = 1; step(8); tx = 0; crs = 1; step(50); crs = 0; step(60);
    // random bursts in each mode
    for (int m = 0; m < 2; m++) begin
      idle_all(); step(5); fd = m[0]; step(2);
      for (int k = 0; k < 40; k++) begin
        pend = 1'($urandom_range(1));
        rx = 1'($urandom_range(3) == 0);
        col = 1'($urandom_range(7) == 0);
        crs = 1'($urandom_range(1));
        if ($urandom_range(3) == 0) begin
          tx = 1; step($urandom_range(20, 4)); tx = 0;
        end
        step($urandom_range(60, 1));
      end
    end
    idle_all(); step(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule